// File: doc/BRIEF.md
# Ranked Top-Four Candidate Selector

This block takes 36 track candidates per bunch crossing, supplied by 12 sources that each contribute 3 candidates. It forwards the four that carry the highest rank. Every candidate word reaches the block in two halves over two consecutive cycles of a fast clock that runs at twice the crossing rate. The block joins the two halves into one word per candidate, orders the candidates by their rank field, and places the payloads of the four best candidates on four output slots.

Alongside the slots, the block returns one winner flag per input. Each source can read from these flags which of its candidates were sent on. The pipeline has a fixed depth, so the results of every crossing appear a constant number of fast-clock cycles after the crossing's second half was captured. Duplicate suppression and any recoding of the output fields belong to other blocks.

Candidate index i is src*3 + cand, where src is 0..11 and cand is 0..2. Half i occupies half_in[16*i +: 16], and slot k occupies win_word[32*k +: 32].

Top module: `quad_rank_select`

## Requirements
- R1: When lo_half is high, the 16-bit halves present in that cycle are taken as bits [15:0] of each word. The halves present in the next cycle are taken as bits [31:16]. The rank is bits [6:0] of the joined word. half_in is ignored in every other cycle.
- R2: The four highest-ranked candidates appear on slots 0 to 3 in descending rank order.
- R3: Among candidates of equal rank, the one with the lower index i is chosen first and placed in the lower slot.
- R4: A candidate of rank 0 never fills a slot. Every slot that has no candidate reads as all zeros.
- R5: win_flag[i] is 1 exactly when candidate i occupies a slot. The flags change on the same clock edge as the slots they describe.
- R6: The slots, the flags and a one-cycle out_vld pulse update on the 5th rising edge after the edge that captured the second half. Between pulses the slots and flags hold their values.
- R7: While rst_n is low, out_vld, every slot and every flag read zero.
- R8: A winning candidate's full 32-bit word, payload included, reaches its slot unchanged.
- R9: Crossings may follow one another with no idle cycles. Each crossing then yields its own result, and successive out_vld pulses are two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the crossing rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_half | input | 1 | Marks the cycle that carries the low halves |
| half_in | input | 576 | 36 candidate half-words, 16 bits each |
| out_vld | output | 1 | One-cycle pulse when new results are loaded |
| win_word | output | 128 | Four winner slots, 32 bits each, slot 0 highest |
| win_flag | output | 36 | Per-input winner flags |

## Verification
The checker assumes that lo_half is never high in two consecutive cycles, since the cycle after a low half always carries the high half. It also assumes that each result on the outputs traces back to exactly one lo_half marker issued a fixed number of cycles earlier. The bench pulses lo_half only as the first cycle of each two-cycle crossing. During idle gaps it keeps lo_half low while it scrambles half_in, so the spacing assumption always holds. Dense tie patterns, sparse and all-zero crossings, and streams of back-to-back crossings are compared against an independent selection model in the bench.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
   localparam int unsigned DEF_NUM_SRC  = 12;
   localparam int unsigned DEF_PER_SRC  = 3;
   localparam int unsigned DEF_WORD_W   = 32;
   localparam int unsigned DEF_RANK_W   = 7;
   localparam int unsigned DEF_NUM_WIN  = 4;
   localparam int unsigned DEF_PAD      = 2;

   // width of a counter able to hold 0..n
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   // fixed latency, in fast cycles, from the high-half capture edge to the outputs
   function automatic int unsigned sort_lat(input int unsigned pad);
      return 3 + pad;
   endfunction
endpackage

// File: rtl/qrs_demux.sv
module qrs_demux #(
   parameter int unsigned N      = 36,
   parameter int unsigned HALF_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lo_half,
   input  logic [N*HALF_W-1:0]   half_in,
   output logic [N*2*HALF_W-1:0] word_q,
   output logic                  word_vld
);
   localparam int unsigned WORD_W = 2 * HALF_W;

   logic [N*HALF_W-1:0] lo_hold;
   logic                hi_pend;
   logic [N*WORD_W-1:0] joined;

   for (genvar i = 0; i < N; i++) begin : g_join
      assign joined[i*WORD_W +: WORD_W] = {half_in[i*HALF_W +: HALF_W], lo_hold[i*HALF_W +: HALF_W]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_hold  <= '0;
         hi_pend  <= 1'b0;
         word_q   <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= 1'b0;
         if (hi_pend) begin
            word_q   <= joined;
            word_vld <= 1'b1;
            hi_pend  <= 1'b0;
         end else if (lo_half) begin
            lo_hold <= half_in;
            hi_pend <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/qrs_rank_pos.sv
module qrs_rank_pos #(
   parameter int unsigned N        = 36,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned RANK_W   = 7,
   parameter int unsigned RANK_LSB = 0,
   parameter int unsigned NUM_WIN  = 4,
   parameter int unsigned PW       = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N*WORD_W-1:0] word_q,
   input  logic                in_vld,
   output logic [N*PW-1:0]     pos_q,
   output logic [N-1:0]        win_q,
   output logic                vld_q
);
   logic [RANK_W-1:0] rnk   [N];
   logic [N-1:0]      beat  [N];
   logic [N*PW-1:0]   pos_d;
   logic [N-1:0]      win_d;

   for (genvar i = 0; i < N; i++) begin : g_rank
      assign rnk[i] = word_q[i*WORD_W + RANK_LSB +: RANK_W];
   end

   // beat[i][j]: candidate j is ordered ahead of candidate i
   for (genvar i = 0; i < N; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         if (j == i) begin : g_self
            assign beat[i][j] = 1'b0;
         end else if (j < i) begin : g_lower
            assign beat[i][j] = (rnk[j] >= rnk[i]);
         end else begin : g_upper
            assign beat[i][j] = (rnk[j] > rnk[i]);
         end
      end
      assign pos_d[i*PW +: PW] = PW'($countones(beat[i]));
      assign win_d[i] = (rnk[i] != '0) && (int'(pos_d[i*PW +: PW]) < int'(NUM_WIN));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         win_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_vld;
         if (in_vld) begin
            pos_q <= pos_d;
            win_q <= win_d;
         end
      end
   end
endmodule

// File: rtl/qrs_merge.sv
module qrs_merge #(
   parameter int unsigned N       = 36,
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned NUM_WIN = 4,
   parameter int unsigned PW      = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N*WORD_W-1:0]       word_q,
   input  logic [N*PW-1:0]           pos_q,
   input  logic [N-1:0]              win_q,
   input  logic                      in_vld,
   output logic [NUM_WIN*WORD_W-1:0] slot_q,
   output logic [N-1:0]              flag_q,
   output logic                      vld_q
);
   logic [NUM_WIN*WORD_W-1:0] slot_d;

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_slot
      always_comb begin
         slot_d[k*WORD_W +: WORD_W] = '0;
         for (int i = 0; i < int'(N); i++) begin
            if (win_q[i] && (int'(pos_q[i*PW +: PW]) == k))
               slot_d[k*WORD_W +: WORD_W] = slot_d[k*WORD_W +: WORD_W] | word_q[i*WORD_W +: WORD_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         flag_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= in_vld;
         if (in_vld) begin
            slot_q <= slot_d;
            flag_q <= win_q;
         end
      end
   end
endmodule

// File: rtl/qrs_delay.sv
module qrs_delay #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] din,
   input  logic          din_vld,
   output logic [DW-1:0] dout,
   output logic          dout_vld
);
   if (DEPTH == 0) begin : g_pass
      assign dout     = din;
      assign dout_vld = din_vld;
   end else begin : g_chain
      logic [DW-1:0]    dq [DEPTH];
      logic [DEPTH-1:0] vq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < int'(DEPTH); s++) dq[s] <= '0;
            vq <= '0;
         end else begin
            dq[0] <= din;
            vq[0] <= din_vld;
            for (int s = 1; s < int'(DEPTH); s++) begin
               dq[s] <= dq[s-1];
               vq[s] <= vq[s-1];
            end
         end
      end
      assign dout     = dq[DEPTH-1];
      assign dout_vld = vq[DEPTH-1];
   end
endmodule

// File: rtl/quad_rank_select.sv
module quad_rank_select #(
   parameter int unsigned NUM_SRC    = qrs_pkg::DEF_NUM_SRC,
   parameter int unsigned PER_SRC    = qrs_pkg::DEF_PER_SRC,
   parameter int unsigned WORD_W     = qrs_pkg::DEF_WORD_W,
   parameter int unsigned RANK_W     = qrs_pkg::DEF_RANK_W,
   parameter int unsigned RANK_LSB   = 0,
   parameter int unsigned NUM_WIN    = qrs_pkg::DEF_NUM_WIN,
   parameter int unsigned PAD_STAGES = qrs_pkg::DEF_PAD,
   localparam int unsigned N         = NUM_SRC * PER_SRC,
   localparam int unsigned HALF_W    = WORD_W / 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      lo_half,
   input  logic [N*HALF_W-1:0]       half_in,
   output logic                      out_vld,
   output logic [NUM_WIN*WORD_W-1:0] win_word,
   output logic [N-1:0]              win_flag
);
   localparam int unsigned PW = qrs_pkg::cnt_w(N);
   localparam int unsigned DW = N + NUM_WIN * WORD_W;

   if (WORD_W % 2 != 0) begin : g_err_even
      $error("WORD_W must be even");
   end
   if (RANK_LSB + RANK_W > HALF_W) begin : g_err_rank
      $error("rank field must lie in the low half");
   end
   if (NUM_WIN == 0 || NUM_WIN > N) begin : g_err_win
      $error("NUM_WIN must be 1..N");
   end

   logic [N*WORD_W-1:0]       word_q;
   logic                      word_vld;
   logic [N*PW-1:0]           pos_q;
   logic [N-1:0]              win_q;
   logic                      pos_vld;
   logic [NUM_WIN*WORD_W-1:0] slot_q;
   logic [N-1:0]              flag_q;
   logic                      mrg_vld;
   logic [DW-1:0]             dly_out;
   logic                      dly_vld;

   qrs_demux #(.N(N), .HALF_W(HALF_W)) u_demux (
      .clk(clk), .rst_n(rst_n), .lo_half(lo_half), .half_in(half_in),
      .word_q(word_q), .word_vld(word_vld));

   qrs_rank_pos #(.N(N), .WORD_W(WORD_W), .RANK_W(RANK_W), .RANK_LSB(RANK_LSB),
                  .NUM_WIN(NUM_WIN), .PW(PW)) u_pos (
      .clk(clk), .rst_n(rst_n), .word_q(word_q), .in_vld(word_vld),
      .pos_q(pos_q), .win_q(win_q), .vld_q(pos_vld));

   qrs_merge #(.N(N), .WORD_W(WORD_W), .NUM_WIN(NUM_WIN), .PW(PW)) u_merge (
      .clk(clk), .rst_n(rst_n), .word_q(word_q), .pos_q(pos_q), .win_q(win_q),
      .in_vld(pos_vld), .slot_q(slot_q), .flag_q(flag_q), .vld_q(mrg_vld));

   qrs_delay #(.DW(DW), .DEPTH(PAD_STAGES)) u_pad (
      .clk(clk), .rst_n(rst_n), .din({flag_q, slot_q}), .din_vld(mrg_vld),
      .dout(dly_out), .dout_vld(dly_vld));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         win_word <= '0;
         win_flag <= '0;
      end else begin
         out_vld <= dly_vld;
         if (dly_vld) begin
            win_word <= dly_out[NUM_WIN*WORD_W-1:0];
            win_flag <= dly_out[DW-1 -: N];
         end
      end
   end
endmodule

// File: rtl/qrs_checker.sv
module qrs_checker #(
   parameter int unsigned N          = 36,
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned RANK_W     = 7,
   parameter int unsigned RANK_LSB   = 0,
   parameter int unsigned NUM_WIN    = 4,
   parameter int unsigned PAD_STAGES = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      lo_half,
   input logic                      out_vld,
   input logic [NUM_WIN*WORD_W-1:0] win_word,
   input logic [N-1:0]              win_flag
);
   localparam int unsigned VL = qrs_pkg::sort_lat(PAD_STAGES) + 2;

   logic [VL-1:0] vsr;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vsr <= '0;
      else        vsr <= {vsr[VL-2:0], lo_half};
   end

   int filled;
   always_comb begin
      filled = 0;
      for (int k = 0; k < int'(NUM_WIN); k++)
         if (win_word[k*WORD_W + RANK_LSB +: RANK_W] != '0) filled++;
   end

   p_lo_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lo_half |=> !lo_half);

   p_fixed_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == vsr[VL-1]);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> ($stable(win_word) && $stable(win_flag)));

   p_flag_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ($countones(win_flag) == filled));

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_slot
      p_empty_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (win_word[k*WORD_W + RANK_LSB +: RANK_W] == '0) |-> (win_word[k*WORD_W +: WORD_W] == '0));
      if (k + 1 < NUM_WIN) begin : g_ord
         p_desc_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld |-> (win_word[k*WORD_W + RANK_LSB +: RANK_W] >= win_word[(k+1)*WORD_W + RANK_LSB +: RANK_W]));
      end
   end
endmodule

bind quad_rank_select qrs_checker #(
   .N(N), .WORD_W(WORD_W), .RANK_W(RANK_W), .RANK_LSB(RANK_LSB),
   .NUM_WIN(NUM_WIN), .PAD_STAGES(PAD_STAGES)
) u_qrs_chk (
   .clk(clk), .rst_n(rst_n), .lo_half(lo_half), .out_vld(out_vld),
   .win_word(win_word), .win_flag(win_flag));

// File: tb/quad_rank_select_test.sv
module quad_rank_select_test;
   localparam int N  = 36;
   localparam int H  = 16;
   localparam int W  = 32;
   localparam int NW = 4;
   localparam int S  = 40;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            lo_half = 1'b0;
   logic [N*H-1:0]  half_in = '0;
   logic            out_vld;
   logic [NW*W-1:0] win_word;
   logic [N-1:0]    win_flag;

   int n_chk = 0;
   int n_fail = 0;

   logic [W-1:0]  dw [N];
   logic [W-1:0]  rw [N];
   logic [W-1:0]  stream_w [S][N];
   logic [W-1:0]  exp_slot [NW];
   logic [N-1:0]  exp_flag;

   always #4ns clk = ~clk;

   quad_rank_select uut (
      .clk(clk), .rst_n(rst_n), .lo_half(lo_half), .half_in(half_in),
      .out_vld(out_vld), .win_word(win_word), .win_flag(win_flag));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // reference: repeated pick of the highest rank, lowest index first, rank 0 excluded
   task automatic compute_exp();
      logic [N-1:0] used;
      used = '0;
      exp_flag = '0;
      for (int k = 0; k < NW; k++) begin
         int best;
         best = -1;
         for (int i = 0; i < N; i++)
            if (!used[i] && rw[i][6:0] != 0 && (best < 0 || rw[i][6:0] > rw[best][6:0])) best = i;
         if (best >= 0) begin
            used[best] = 1'b1;
            exp_flag[best] = 1'b1;
            exp_slot[k] = rw[best];
         end else exp_slot[k] = '0;
      end
   endtask

   task automatic drive_xing();
      @(negedge clk);
      lo_half = 1'b1;
      for (int i = 0; i < N; i++) half_in[i*H +: H] = dw[i][15:0];
      @(negedge clk);
      lo_half = 1'b0;
      for (int i = 0; i < N; i++) half_in[i*H +: H] = dw[i][31:16];
   endtask

   task automatic cmp_outputs(input string tag);
      for (int k = 0; k < NW; k++)
         chk(win_word[k*W +: W] == exp_slot[k], tag, 64'(win_word[k*W +: W]), 64'(exp_slot[k]));
      chk(win_flag == exp_flag, {tag, " R5 flags"}, 64'(win_flag), 64'(exp_flag));
   endtask

   // one isolated crossing, with latency, pulse and hold checks
   task automatic run_one(input string tag);
      logic [NW*W-1:0] held;
      for (int i = 0; i < N; i++) rw[i] = dw[i];
      compute_exp();
      drive_xing();
      @(posedge clk);                       // high half captured here
      @(negedge clk);
      half_in = {N{16'hDEAD}};              // scrambled while idle: must be ignored (R1)
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(out_vld == 1'b0, "R6 early", 64'(out_vld), 64'd0);
      @(posedge clk);
      @(negedge clk);
      chk(out_vld == 1'b1, "R6 pulse", 64'(out_vld), 64'd1);
      cmp_outputs(tag);
      held = win_word;
      @(negedge clk);
      chk(out_vld == 1'b0, "R6 one cycle", 64'(out_vld), 64'd0);
      chk(win_word == held, "R6 hold", 64'(win_word[63:0]), 64'(held[63:0]));
   endtask

   task automatic t_reset();
      chk(out_vld == 1'b0, "R7 vld", 64'(out_vld), 64'd0);
      chk(win_word == '0, "R7 slots", 64'(win_word[63:0]), 64'd0);
      chk(win_flag == '0, "R7 flags", 64'(win_flag), 64'd0);
   endtask

   task automatic t_distinct();
      for (int i = 0; i < N; i++) dw[i] = {8'(i * 7), 8'hA5 ^ 8'(i), 9'(i), 7'((i * 53) % 97 + 1)};
      run_one("R2 R8 distinct");
   endtask

   task automatic t_ties();
      for (int i = 0; i < N; i++) dw[i] = {16'h1000 + 16'(i), 9'd0, 7'd50};
      run_one("R3 all tied");
      for (int i = 0; i < N; i++) dw[i] = {16'h2000 + 16'(i), 9'd0, 7'd10};
      dw[35][6:0] = 7'd100; dw[34][6:0] = 7'd100; dw[1][6:0] = 7'd100; dw[20][6:0] = 7'd100; dw[3][6:0] = 7'd100;
      run_one("R3 tie at boundary");
   endtask

   task automatic t_sparse();
      for (int i = 0; i < N; i++) dw[i] = {16'hFFFF, 9'h1FF, 7'd0};
      dw[17] = {16'h1717, 9'h011, 7'd3};
      dw[30] = {16'h3030, 9'h030, 7'd90};
      run_one("R4 R8 two present");
      for (int i = 0; i < N; i++) dw[i] = {16'hBEEF, 9'h155, 7'd0};
      run_one("R4 all zero rank");
   endtask

   task automatic t_idle_ignored();
      logic [NW*W-1:0] held;
      held = win_word;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         half_in = {18{$urandom()}};
         chk(out_vld == 1'b0 && win_word == held, "R1 idle ignored", 64'(win_word[63:0]), 64'(held[63:0]));
      end
   endtask

   task automatic t_stream(input int rmax);
      for (int x = 0; x < S; x++)
         for (int i = 0; i < N; i++)
            stream_w[x][i] = {$urandom(), 7'($urandom_range(0, rmax))};
      fork
         begin
            for (int x = 0; x < S; x++) begin
               for (int i = 0; i < N; i++) dw[i] = stream_w[x][i];
               drive_xing();
            end
         end
         begin
            int gap;
            gap = 0;
            for (int x = 0; x < S; x++) begin
               do begin
                  @(negedge clk);
                  gap++;
               end while (!out_vld);
               if (x > 0) chk(gap == 2, "R9 spacing", 64'(gap), 64'd2);
               gap = 0;
               for (int i = 0; i < N; i++) rw[i] = stream_w[x][i];
               compute_exp();
               cmp_outputs("R9 R2 R3 stream");
            end
         end
      join
   endtask

   initial begin
      #(8ns * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_distinct();
      t_ties();
      t_sparse();
      t_idle_ignored();
      t_stream(3);
      t_stream(127);
      t_stream(1);
      repeat (10) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule